// File: doc/BRIEF.md
# Line-Side Maintenance and Loopback Control

This block sits in the serial datapath of an E2/E3 framer, between the terminal-side bit stream, the line coder and the line pins. It chooses where each transmitted and received bit comes from and which bit timing drives it. Two loopbacks are provided. The terminal loopback turns the outgoing line bit back into the receive path. The payload loopback turns the received bit back into the transmit path. Loop timing makes the transmit side run on the recovered receive timing. An alarm control replaces the outgoing stream with all ones. A falling edge on an asynchronous pin corrupts exactly one framing-pattern bit.

The whole block runs on one core clock. Line and terminal bit timing arrive as one-cycle enable strobes, so loop timing means picking a strobe and never switching a clock. A bypass select chooses the line mode. In single-rail NRZ mode the line coder is skipped. In dual-rail mode the line coder is used, and its rails and decoded data pass through this block. The framer supplies a marker that flags which transmit bit positions belong to the framing pattern.

Top module: `line_maint_ctl`

## Requirements
- R1: While rst_n is low at a clock edge, the registered outputs tx_nrz_o and rx_data_o go to 0. With the default inputs they stay 0 until the first strobe after reset.
- R2: With nrz_sel_i=1, tx_line_p_o equals tx_nrz_o and tx_line_n_o, enc_data_o, dec_p_o and dec_n_o are 0. The received line bit is rx_line_p_i. With nrz_sel_i=0, tx_line_p_o/tx_line_n_o follow enc_p_i/enc_n_i, enc_data_o equals tx_nrz_o, dec_p_o/dec_n_o follow rx_line_p_i/rx_line_n_i, and the received line bit is dec_data_i.
- R3: With no maintenance control active, a transmit strobe at edge k loads tx_data_i into tx_nrz_o, and rx_bit_en_i at edge k loads the received line bit into rx_data_o. Without a strobe, each of these outputs holds its value.
- R4: With lpt_n_i=1 the transmit strobe tx_stb_o is tx_bit_en_i. With lpt_n_i=0 it is rx_bit_en_i, and tx_bit_en_i has no effect.
- R5: With tlbk_n_i=0, rx_stb_o equals the transmit strobe, and rx_data_o is loaded with the same bit that tx_nrz_o takes at that edge. The received line bit is ignored.
- R6: With plbk_n_i=0, ser_sel_i=1 and tlbk_n_i=1, the transmit source is the value rx_data_o holds just before the strobe edge, and tx_data_i is ignored.
- R7: With ser_sel_i=0, plbk_n_i has no effect and the transmit source stays tx_data_i.
- R8: When tlbk_n_i and plbk_n_i are both 0, the terminal loopback applies and the transmit source is tx_data_i.
- R9: With ais_n_i=0 every transmitted bit is 1. This holds after the source has been selected and after any framing error, so the terminal loopback also receives ones.
- R10: Suppose ferr_n_i, after being high for at least three edges, is first sampled low at edge k. Then the first transmit strobe with tx_frm_i=1 at edge k+3 or later sends the selected bit inverted, and exactly one bit is inverted.
- R11: A further falling edge of ferr_n_i is ignored while an inversion is pending. This includes an edge recognised in the same cycle as the errored framing bit is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_bit_en_i | input | 1 | Local transmit bit strobe |
| tx_data_i | input | 1 | Terminal-side transmit bit |
| tx_frm_i | input | 1 | Marks the current transmit bit as a framing-pattern bit |
| rx_bit_en_i | input | 1 | Recovered receive bit strobe |
| rx_line_p_i | input | 1 | Receive line positive rail, or NRZ data |
| rx_line_n_i | input | 1 | Receive line negative rail |
| enc_p_i | input | 1 | Positive rail from the line encoder |
| enc_n_i | input | 1 | Negative rail from the line encoder |
| dec_data_i | input | 1 | Decoded bit from the line decoder |
| nrz_sel_i | input | 1 | 1 selects single-rail NRZ with coder bypassed |
| ser_sel_i | input | 1 | 1 means bit-serial terminal interface |
| tlbk_n_i | input | 1 | Terminal loopback, active low |
| plbk_n_i | input | 1 | Payload loopback, active low |
| ais_n_i | input | 1 | All-ones alarm substitution, active low |
| lpt_n_i | input | 1 | Loop timing, active low |
| ferr_n_i | input | 1 | Asynchronous force-framing-error pin, falling edge acts |
| tx_stb_o | output | 1 | Selected transmit bit strobe |
| tx_nrz_o | output | 1 | Transmitted bit, logic level |
| enc_data_o | output | 1 | Bit to the line encoder |
| tx_line_p_o | output | 1 | Transmit line positive rail, or NRZ data |
| tx_line_n_o | output | 1 | Transmit line negative rail |
| dec_p_o | output | 1 | Positive rail to the line decoder |
| dec_n_o | output | 1 | Negative rail to the line decoder |
| rx_stb_o | output | 1 | Selected receive bit strobe |
| rx_data_o | output | 1 | Received bit to the terminal side |

## Verification
The framing-error injection and the alarm substitution can act on the same transmit strobe. The injection can also meet a second error edge in the very cycle its errored bit leaves. Random runs drive the alarm pin and the error pin together with framing markers, and a bench model flags the cycles where a pending inversion meets a framing strobe. Directed sequences time a second pin fall so that it is recognised exactly on the consuming framing strobe. The result is judged at the pins: the count of inverted framing bits must be one, and no bit may leave as 0 while the alarm is active.

// File: rtl/lmc_pkg.sv
// Shared types for the line maintenance control block.
// Assumes: controls are active low at the pins and quasi-static relative to the core clock.
package lmc_pkg;

    // Resolved maintenance state after priority and mode restrictions.
    typedef struct packed {
        logic term_loop;
        logic pay_loop;
        logic alarm;
        logic loop_time;
    } lmc_ctl_t;

    typedef enum logic {
        TXS_TERMINAL = 1'b0,
        TXS_PAYLOAD  = 1'b1
    } lmc_tx_src_e;

    typedef enum logic {
        RXS_LINE      = 1'b0,
        RXS_TERM_LOOP = 1'b1
    } lmc_rx_src_e;

    // Resolve the active-low pins: terminal loopback wins, payload loopback needs serial mode.
    function automatic lmc_ctl_t lmc_resolve(input logic tlbk_n, input logic plbk_n,
                                             input logic ais_n, input logic lpt_n,
                                             input logic ser_sel);
        lmc_ctl_t c;
        c.term_loop = ~tlbk_n;
        c.pay_loop  = ~plbk_n & ser_sel & tlbk_n;
        c.alarm     = ~ais_n;
        c.loop_time = ~lpt_n;
        return c;
    endfunction

endpackage

// File: rtl/lmc_ferr_inject.sv
// Force-error injector: synchronises the asynchronous pin, detects a falling edge and
// keeps one inversion pending until a framing bit consumes it.
// Assumes: the pin idles high; edges arriving while an inversion is pending are dropped.
module lmc_ferr_inject #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ferr_n_i,
    input  logic frm_stb_i,   // a framing bit is sent at this edge
    output logic invert_o,    // invert the framing bit sent at this edge
    output logic pending_o
);
    localparam int SHW = SYNC_STAGES + 1;

    logic [SHW-1:0] sync_q;
    logic           pending_q;
    logic           fall_det;

    // Synchroniser chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SHW-2:0], ferr_n_i};
    end

    assign fall_det = sync_q[SHW-1] & ~sync_q[SHW-2];

    // Pending flag: set by an edge when idle, cleared by the consuming framing bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          pending_q <= 1'b0;
        else if (pending_q)  pending_q <= ~frm_stb_i;
        else if (fall_det)   pending_q <= 1'b1;
    end

    assign invert_o  = pending_q & frm_stb_i;
    assign pending_o = pending_q;

    // R10
    consume_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && frm_stb_i) |=> !pending_q);

    // R11
    hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !frm_stb_i) |=> pending_q);

endmodule

// File: rtl/lmc_tx_path.sv
// Transmit bit register: selects terminal or payload-loop source, applies a framing
// inversion, then the all-ones alarm, and loads on the selected transmit strobe.
// Assumes: strobes are single-cycle enables in the core clock domain.
module lmc_tx_path
    import lmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stb_i,
    input  lmc_tx_src_e src_i,
    input  logic        term_data_i,
    input  logic        loop_data_i,
    input  logic        invert_i,
    input  logic        alarm_i,
    output logic        bit_next_o,
    output logic        bit_q_o
);
    logic src_bit;
    logic bit_q;

    // Source choice, then error inversion, then alarm override.
    always_comb begin
        src_bit    = (src_i == TXS_PAYLOAD) ? loop_data_i : term_data_i;
        bit_next_o = alarm_i ? 1'b1 : (src_bit ^ invert_i);
    end

    // Transmitted bit register, updated only on a transmit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     bit_q <= 1'b0;
        else if (stb_i) bit_q <= bit_next_o;
    end

    assign bit_q_o = bit_q;

endmodule

// File: rtl/lmc_rx_path.sv
// Receive bit register: picks the line bit (NRZ pin or decoder) or the looped
// transmit bit and loads it on the selected receive strobe.
// Assumes: the looped bit is the final transmitted value of the same strobe.
module lmc_rx_path
    import lmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stb_i,
    input  lmc_rx_src_e src_i,
    input  logic        nrz_sel_i,
    input  logic        nrz_data_i,
    input  logic        dec_data_i,
    input  logic        loop_data_i,
    output logic        bit_q_o
);
    logic line_bit;
    logic bit_q;

    // Line bit by coding mode, then loopback override.
    always_comb begin
        line_bit = nrz_sel_i ? nrz_data_i : dec_data_i;
    end

    // Received bit register, updated only on a receive strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     bit_q <= 1'b0;
        else if (stb_i) bit_q <= (src_i == RXS_TERM_LOOP) ? loop_data_i : line_bit;
    end

    assign bit_q_o = bit_q;

endmodule

// File: rtl/lmc_line_steer.sv
// Line-side steering between single-rail NRZ and the dual-rail coder path.
// Assumes: in NRZ mode the coder inputs are parked at 0 and the negative rail is unused.
module lmc_line_steer (
    input  logic nrz_sel_i,
    input  logic tx_bit_i,
    input  logic enc_p_i,
    input  logic enc_n_i,
    input  logic rx_p_i,
    input  logic rx_n_i,
    output logic enc_data_o,
    output logic tx_p_o,
    output logic tx_n_o,
    output logic dec_p_o,
    output logic dec_n_o
);
    // Route transmit and receive rails by coding mode.
    always_comb begin
        if (nrz_sel_i) begin
            enc_data_o = 1'b0;
            tx_p_o     = tx_bit_i;
            tx_n_o     = 1'b0;
            dec_p_o    = 1'b0;
            dec_n_o    = 1'b0;
        end else begin
            enc_data_o = tx_bit_i;
            tx_p_o     = enc_p_i;
            tx_n_o     = enc_n_i;
            dec_p_o    = rx_p_i;
            dec_n_o    = rx_n_i;
        end
    end

endmodule

// File: rtl/line_maint_ctl.sv
// Top of the line maintenance control block: resolves the maintenance pins, selects
// the bit strobes, and wires the transmit, receive, error and line-steering parts.
// Assumes: one core clock; line and terminal bit timing arrive as enable strobes.
module line_maint_ctl
    import lmc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_bit_en_i,
    input  logic tx_data_i,
    input  logic tx_frm_i,
    input  logic rx_bit_en_i,
    input  logic rx_line_p_i,
    input  logic rx_line_n_i,
    input  logic enc_p_i,
    input  logic enc_n_i,
    input  logic dec_data_i,
    input  logic nrz_sel_i,
    input  logic ser_sel_i,
    input  logic tlbk_n_i,
    input  logic plbk_n_i,
    input  logic ais_n_i,
    input  logic lpt_n_i,
    input  logic ferr_n_i,
    output logic tx_stb_o,
    output logic tx_nrz_o,
    output logic enc_data_o,
    output logic tx_line_p_o,
    output logic tx_line_n_o,
    output logic dec_p_o,
    output logic dec_n_o,
    output logic rx_stb_o,
    output logic rx_data_o
);
    lmc_ctl_t    ctl;
    lmc_tx_src_e tx_src;
    lmc_rx_src_e rx_src;
    logic        tx_stb;
    logic        rx_stb;
    logic        invert;
    logic        pending;
    logic        tx_next;
    logic        tx_q;
    logic        rx_q;

    // Resolve pins into maintenance state, sources and strobes.
    always_comb begin
        ctl    = lmc_resolve(tlbk_n_i, plbk_n_i, ais_n_i, lpt_n_i, ser_sel_i);
        tx_src = ctl.pay_loop ? TXS_PAYLOAD : TXS_TERMINAL;
        rx_src = ctl.term_loop ? RXS_TERM_LOOP : RXS_LINE;
        tx_stb = ctl.loop_time ? rx_bit_en_i : tx_bit_en_i;
        rx_stb = ctl.term_loop ? tx_stb : rx_bit_en_i;
    end

    lmc_ferr_inject #(.SYNC_STAGES(SYNC_STAGES)) u_ferr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ferr_n_i  (ferr_n_i),
        .frm_stb_i (tx_stb & tx_frm_i),
        .invert_o  (invert),
        .pending_o (pending)
    );

    lmc_tx_path u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_i       (tx_stb),
        .src_i       (tx_src),
        .term_data_i (tx_data_i),
        .loop_data_i (rx_q),
        .invert_i    (invert),
        .alarm_i     (ctl.alarm),
        .bit_next_o  (tx_next),
        .bit_q_o     (tx_q)
    );

    lmc_rx_path u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_i       (rx_stb),
        .src_i       (rx_src),
        .nrz_sel_i   (nrz_sel_i),
        .nrz_data_i  (rx_line_p_i),
        .dec_data_i  (dec_data_i),
        .loop_data_i (tx_next),
        .bit_q_o     (rx_q)
    );

    lmc_line_steer u_steer (
        .nrz_sel_i  (nrz_sel_i),
        .tx_bit_i   (tx_q),
        .enc_p_i    (enc_p_i),
        .enc_n_i    (enc_n_i),
        .rx_p_i     (rx_line_p_i),
        .rx_n_i     (rx_line_n_i),
        .enc_data_o (enc_data_o),
        .tx_p_o     (tx_line_p_o),
        .tx_n_o     (tx_line_n_o),
        .dec_p_o    (dec_p_o),
        .dec_n_o    (dec_n_o)
    );

    assign tx_stb_o  = tx_stb;
    assign rx_stb_o  = rx_stb;
    assign tx_nrz_o  = tx_q;
    assign rx_data_o = rx_q;

    // R5
    term_loop_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tlbk_n_i && tx_stb) |=> (rx_data_o == tx_nrz_o));

    // R6
    pay_loop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!plbk_n_i && ser_sel_i && tlbk_n_i && ais_n_i && tx_stb && !pending)
        |=> (tx_nrz_o == $past(rx_data_o)));

    // R7
    pay_loop_serial_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_sel_i && ais_n_i && tx_stb && !pending)
        |=> (tx_nrz_o == $past(tx_data_i)));

    // R9
    alarm_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ais_n_i && tx_stb) |=> tx_nrz_o);

endmodule

// File: tb/line_maint_ctl_tb_top.sv
// Bench: random and directed stimulus, checked against a requirement-level model.
module line_maint_ctl_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic tx_bit_en, tx_data, tx_frm, rx_bit_en, rx_p, rx_n, enc_p, enc_n, dec_data;
    logic nrz_sel, ser_sel, tlbk_n, plbk_n, ais_n, lpt_n, ferr_n;
    logic tx_stb_o, tx_nrz_o, enc_data_o, tx_line_p_o, tx_line_n_o;
    logic dec_p_o, dec_n_o, rx_stb_o, rx_data_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // Model state
    logic       m_tx, m_rx, m_arm;
    logic [2:0] m_sh;

    always #4 clk = ~clk;

    line_maint_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_bit_en_i(tx_bit_en), .tx_data_i(tx_data), .tx_frm_i(tx_frm),
        .rx_bit_en_i(rx_bit_en), .rx_line_p_i(rx_p), .rx_line_n_i(rx_n),
        .enc_p_i(enc_p), .enc_n_i(enc_n), .dec_data_i(dec_data),
        .nrz_sel_i(nrz_sel), .ser_sel_i(ser_sel), .tlbk_n_i(tlbk_n), .plbk_n_i(plbk_n),
        .ais_n_i(ais_n), .lpt_n_i(lpt_n), .ferr_n_i(ferr_n),
        .tx_stb_o(tx_stb_o), .tx_nrz_o(tx_nrz_o), .enc_data_o(enc_data_o),
        .tx_line_p_o(tx_line_p_o), .tx_line_n_o(tx_line_n_o),
        .dec_p_o(dec_p_o), .dec_n_o(dec_n_o), .rx_stb_o(rx_stb_o), .rx_data_o(rx_data_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic rnd_low(input int pct);
        return (($urandom % 100) < pct) ? 1'b0 : 1'b1;
    endfunction

    task automatic idle_inputs();
        tx_bit_en = 0; tx_data = 0; tx_frm = 0; rx_bit_en = 0; rx_p = 0; rx_n = 0;
        enc_p = 0; enc_n = 0; dec_data = 0; nrz_sel = 1; ser_sel = 1;
        tlbk_n = 1; plbk_n = 1; ais_n = 1; lpt_n = 1; ferr_n = 1;
    endtask

    // One cycle: inputs already driven after a falling edge; check, advance model, check.
    task automatic step();
        logic tstb, tl, pl, inv, nxt, line, rstb, fall;
        string ttag, rtag;
        #1;
        tstb = lpt_n ? tx_bit_en : rx_bit_en;
        tl   = ~tlbk_n;
        pl   = ~plbk_n & ser_sel & tlbk_n;
        inv  = m_arm & tstb & tx_frm;
        nxt  = ~ais_n ? 1'b1 : ((pl ? m_rx : tx_data) ^ inv);
        line = nrz_sel ? rx_p : dec_data;
        rstb = tl ? tstb : rx_bit_en;
        fall = m_sh[2] & ~m_sh[1];
        // R4 strobe selection, R5 receive strobe follows transmit in loopback
        check("R4 tx_stb", tx_stb_o, tstb);
        check("R5 rx_stb", rx_stb_o, rstb);
        // R2 line steering
        check("R2 tx_line_p", tx_line_p_o, nrz_sel ? m_tx : enc_p);
        check("R2 tx_line_n", tx_line_n_o, nrz_sel ? 1'b0 : enc_n);
        check("R2 enc_data", enc_data_o, nrz_sel ? 1'b0 : m_tx);
        check("R2 dec_p", dec_p_o, nrz_sel ? 1'b0 : rx_p);
        check("R2 dec_n", dec_n_o, nrz_sel ? 1'b0 : rx_n);
        if (~ais_n)                      ttag = "R9 tx";
        else if (inv)                    ttag = "R10 tx";
        else if (tl && ~plbk_n)          ttag = "R8 tx";
        else if (pl)                     ttag = "R6 tx";
        else if (~plbk_n && !ser_sel)    ttag = "R7 tx";
        else if (~lpt_n)                 ttag = "R4 tx";
        else                             ttag = "R3 tx";
        rtag = tl ? "R5 rx" : (nrz_sel ? "R3 rx nrz" : "R2 rx decoder");
        @(posedge clk);
        cycles++;
        if (tstb) m_tx = nxt;
        if (rstb) m_rx = tl ? nxt : line;
        m_arm = m_arm ? ~(tstb & tx_frm) : fall;
        m_sh  = {m_sh[1:0], ferr_n};
        @(negedge clk);
        check(ttag, tx_nrz_o, m_tx);
        check(rtag, rx_data_o, m_rx);
    endtask

    // Count transmitted ones over n framing strobes with zero data (R10/R11 directed).
    task automatic count_frame_ones(input int n, output int ones);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            tx_bit_en = 1; tx_frm = 1; tx_data = 0;
            step();
            ones += int'(tx_nrz_o);
        end
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            if (cycles > 150000 && !done) begin
                fails++; checks++;
                $display("FAIL watchdog: actual hung expected finish");
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin : main
        int ones;
        void'($urandom(32'h1A2B3C4D));
        idle_inputs();
        rst_n = 0;
        m_tx = 0; m_rx = 0; m_arm = 0; m_sh = 3'b111;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 tx_nrz reset", tx_nrz_o, 1'b0);
        check("R1 rx_data reset", rx_data_o, 1'b0);
        step();
        check("R1 tx_nrz idle", tx_nrz_o, 1'b0);

        // Random mix over all controls, with sparse pin toggles.
        for (int i = 0; i < 6000; i++) begin
            tx_bit_en = $urandom % 2; rx_bit_en = $urandom % 2;
            tx_data = $urandom % 2; tx_frm = ($urandom % 4) == 0;
            rx_p = $urandom % 2; rx_n = $urandom % 2; enc_p = $urandom % 2;
            enc_n = $urandom % 2; dec_data = $urandom % 2;
            if (($urandom % 16) == 0) begin
                nrz_sel = $urandom % 2; ser_sel = $urandom % 2;
                tlbk_n = rnd_low(30); plbk_n = rnd_low(40);
                ais_n = rnd_low(20); lpt_n = rnd_low(30);
            end
            if (($urandom % 6) == 0) ferr_n = ~ferr_n;
            step();
        end

        // R10 directed: one fall gives exactly one errored framing bit.
        idle_inputs();
        repeat (4) step();
        ferr_n = 0;
        repeat (3) step();
        count_frame_ones(8, ones);
        check("R10 single inversion", ones == 1, 1'b1);

        // R11 directed: second fall while pending is dropped.
        idle_inputs();
        repeat (4) step();
        ferr_n = 0; repeat (4) step();
        ferr_n = 1; repeat (4) step();
        ferr_n = 0; repeat (4) step();
        count_frame_ones(8, ones);
        check("R11 pending fall ignored", ones == 1, 1'b1);

        // R11 collision: fall recognised in the cycle the errored bit leaves.
        idle_inputs();
        repeat (4) step();
        ferr_n = 0; repeat (4) step();   // inversion pending, no framing bits yet
        ferr_n = 1; repeat (4) step();
        ferr_n = 0; step();              // sampled low
        step();                          // synchroniser
        count_frame_ones(8, ones);       // first strobe consumes while edge is seen
        check("R11 same-cycle fall ignored", ones == 1, 1'b1);

        // R9 with pending error: alarm still forces ones.
        idle_inputs();
        ferr_n = 1; repeat (4) step();
        ferr_n = 0; repeat (4) step();
        ais_n = 0;
        count_frame_ones(4, ones);
        check("R9 alarm over error", ones == 4, 1'b1);

        // R8 priority: both loopbacks, terminal data goes out and loops back.
        idle_inputs();
        tlbk_n = 0; plbk_n = 0;
        for (int i = 0; i < 16; i++) begin
            tx_bit_en = 1; tx_data = $urandom % 2; rx_p = $urandom % 2;
            step();
            check("R8 tx follows terminal", tx_nrz_o, tx_data);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule